// File: doc/BRIEF.md
# Ethernet Receive Frame Error Classifier

This block sits on the receive path of an Ethernet MAC, between the deserialiser on the PHY side and the receive FIFO writer. It watches each frame one byte at a time. It forwards the bytes it keeps and, when the frame closes, issues a single status word that says what went wrong with the frame.

While a frame streams in, the block keeps a running CRC-32 and a byte count. It compares that count with a maximum length that software programs. When the frame ends, the CRC is judged on the last whole byte. Up to seven trailing dribble bits, which the deserialiser reports with the final byte, are tolerated. Whether dribble bits were present decides which CRC error is reported: the misaligned-frame error or the plain CRC error. A frame that grows past the hard limit keeps its status but loses its excess bytes. A FIFO overrun closes the frame at once.

Top module: `rx_frame_classifier`

## Requirements
- R1: Each accepted byte whose running count is at most TRUNC_LEN appears on `out_data_o` with `out_valid_o` high exactly one cycle after the beat that carried it, in arrival order.
- R2: The beat with `rx_last_i` high is the final whole byte of a frame. One cycle after it, `stat_done_o` pulses for one cycle. All status flags are low whenever `stat_done_o` is low.
- R3: The CRC uses the bit-reflected polynomial 0xEDB88320 with the register preset to all ones. Bytes are shifted in LSB first. The frame check sequence is the complement of the CRC over the payload, appended least significant byte first. A frame is good when the register holds 0xDEBB20E3 after its last whole byte. A good frame with a zero dribble count reports no flags.
- R4: CRC checking has no disable. A failed CRC with a zero dribble count sets `stat_cr_o` only.
- R5: With a dribble count of 1 to 7, a failed CRC sets `stat_no_o` only, and a passing CRC sets no flag. Dribble bits are never fed into the CRC.
- R6: `stat_lg_o` is set when the frame's byte count exceeds the maximum length. A count equal to the maximum does not set it. The maximum is sampled on the first beat of each frame, and later changes to `max_len_i` do not affect that frame.
- R7: `babble_irq_o` pulses once per oversize frame. The pulse comes one cycle after the beat that brings the count to the maximum plus one.
- R8: Bytes past the TRUNC_LEN-th byte are not forwarded. In that case `stat_trunc_o` is set in the frame's status.
- R9: `rx_ovf_i` on a beat of an open frame closes that frame: `stat_done_o` rises with `stat_ov_o` one cycle later, and that byte is not forwarded. NO and CR are masked in that status. Further beats up to and including the next `rx_last_i` beat are discarded without output or status. The frame after that is handled normally.
- R10: `stat_no_o` and `stat_cr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | A byte is present this cycle |
| rx_data_i | input | 8 | Received byte |
| rx_last_i | input | 1 | Final whole byte of the frame |
| rx_dribble_i | input | 3 | Leftover bits after the final byte, valid with rx_last_i |
| rx_ovf_i | input | 1 | Receive FIFO overrun, qualified by rx_valid_i |
| max_len_i | input | MAX_W | Programmed maximum frame length in bytes |
| out_valid_o | output | 1 | Forwarded byte valid |
| out_data_o | output | 8 | Forwarded byte |
| stat_done_o | output | 1 | Frame status valid (one cycle) |
| stat_no_o | output | 1 | Misaligned frame with CRC failure |
| stat_cr_o | output | 1 | CRC failure on an aligned frame |
| stat_lg_o | output | 1 | Frame longer than maximum |
| stat_ov_o | output | 1 | Frame closed by FIFO overrun |
| stat_trunc_o | output | 1 | Frame bytes were dropped by the hard limit |
| babble_irq_o | output | 1 | Oversize frame pulse |

## Verification
The bench builds the block with its defaults: MAX_W of 11 and TRUNC_LEN of 2047, which gives a 12-bit internal counter. These values keep the real hard limit in play, so one frame of a little over 2050 bytes reaches the truncation boundary and crosses a maximum programmed to 2047 in the same run. Short frames with a maximum of 20 or 30 exercise the equal-to-maximum and maximum-plus-one boundaries, and they also cover re-sampling of the maximum in the middle of a frame.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_GOOD_RES  = 32'hDEBB20E3;

    typedef struct packed {
        logic        drop;
        logic [31:0] crc;
        logic        oval;
        logic [7:0]  odat;
        logic        done;
        logic        no;
        logic        cr;
        logic        lg;
        logic        ov;
        logic        trunc;
        logic        irq;
    } rxfc_state_t;

endpackage

// File: rtl/rxfc_crc_step.sv
module rxfc_crc_step #(
    parameter logic [31:0] POLY   = 32'hEDB88320,
    parameter int          BYTE_W = 8
) (
    input  logic [31:0]       crc_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [31:0]       crc_o
);

    logic [31:0] acc [0:BYTE_W];

    assign acc[0] = crc_i;

    // one reflected shift per data bit, least significant first
    generate
        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            logic fb;
            assign fb         = acc[b][0] ^ data_i[b];
            assign acc[b + 1] = (acc[b] >> 1) ^ (fb ? POLY : 32'h0);
        end
    endgenerate

    assign crc_o = acc[BYTE_W];

endmodule

// File: rtl/rxfc_len_track.sv
module rxfc_len_track #(
    parameter int MAX_W     = 11,
    parameter int CNT_W     = 12,
    parameter int TRUNC_LEN = 2047
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic [MAX_W-1:0] max_len_i,
    output logic             over_o,
    output logic             cross_o,
    output logic             keep_o
);

    localparam int               PAD_W   = CNT_W - MAX_W;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CUT     = CNT_W'(TRUNC_LEN);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [MAX_W-1:0] max_d, max_q;

    logic             first;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] max_eff;

    always_comb begin
        first    = (cnt_q == '0);
        max_eff  = {{PAD_W{1'b0}}, (first ? max_len_i : max_q)};
        cnt_next = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;

        over_o   = cnt_next > max_eff;
        cross_o  = step_i && over_o && !(cnt_q > max_eff);
        keep_o   = cnt_next <= CUT;

        max_d    = (step_i && first) ? max_len_i : max_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_next;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            max_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            max_q <= max_d;
        end
    end

endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
    import rxfc_pkg::*;
#(
    parameter int MAX_W     = 11,
    parameter int TRUNC_LEN = 2047
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_data_i,
    input  logic             rx_last_i,
    input  logic [2:0]       rx_dribble_i,
    input  logic             rx_ovf_i,
    input  logic [MAX_W-1:0] max_len_i,
    output logic             out_valid_o,
    output logic [7:0]       out_data_o,
    output logic             stat_done_o,
    output logic             stat_no_o,
    output logic             stat_cr_o,
    output logic             stat_lg_o,
    output logic             stat_ov_o,
    output logic             stat_trunc_o,
    output logic             babble_irq_o
);

    localparam int TRUNC_W = $clog2(TRUNC_LEN + 1);
    localparam int CNT_W   = ((MAX_W > TRUNC_W) ? MAX_W : TRUNC_W) + 1;

    rxfc_state_t st_d, st_q;

    logic        take;
    logic        close;
    logic        len_over;
    logic        len_cross;
    logic        len_keep;
    logic [31:0] crc_next;
    logic        crc_ok;

    assign take  = rx_valid_i && !st_q.drop;
    assign close = take && (rx_last_i || rx_ovf_i);

    rxfc_crc_step #(
        .POLY   (CRC_POLY_REFL),
        .BYTE_W (8)
    ) i_crc (
        .crc_i  (st_q.crc),
        .data_i (rx_data_i),
        .crc_o  (crc_next)
    );

    rxfc_len_track #(
        .MAX_W     (MAX_W),
        .CNT_W     (CNT_W),
        .TRUNC_LEN (TRUNC_LEN)
    ) i_len (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (take),
        .clr_i     (close),
        .max_len_i (max_len_i),
        .over_o    (len_over),
        .cross_o   (len_cross),
        .keep_o    (len_keep)
    );

    assign crc_ok = (crc_next == CRC_GOOD_RES);

    always_comb begin
        st_d       = st_q;
        st_d.oval  = 1'b0;
        st_d.done  = 1'b0;
        st_d.no    = 1'b0;
        st_d.cr    = 1'b0;
        st_d.lg    = 1'b0;
        st_d.ov    = 1'b0;
        st_d.trunc = 1'b0;
        st_d.irq   = 1'b0;

        if (rx_valid_i && st_q.drop && rx_last_i) begin
            st_d.drop = 1'b0;
        end

        if (take) begin
            st_d.irq = len_cross;
            if (rx_ovf_i) begin
                st_d.done  = 1'b1;
                st_d.ov    = 1'b1;
                st_d.lg    = len_over;
                st_d.trunc = !len_keep;
                st_d.crc   = CRC_PRESET;
                st_d.drop  = !rx_last_i;
            end else begin
                st_d.oval = len_keep;
                if (len_keep) begin
                    st_d.odat = rx_data_i;
                end
                st_d.crc = crc_next;
                if (rx_last_i) begin
                    st_d.done  = 1'b1;
                    st_d.no    = (rx_dribble_i != 3'd0) && !crc_ok;
                    st_d.cr    = (rx_dribble_i == 3'd0) && !crc_ok;
                    st_d.lg    = len_over;
                    st_d.trunc = !len_keep;
                    st_d.crc   = CRC_PRESET;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.crc  <= CRC_PRESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o  = st_q.oval;
    assign out_data_o   = st_q.odat;
    assign stat_done_o  = st_q.done;
    assign stat_no_o    = st_q.no;
    assign stat_cr_o    = st_q.cr;
    assign stat_lg_o    = st_q.lg;
    assign stat_ov_o    = st_q.ov;
    assign stat_trunc_o = st_q.trunc;
    assign babble_irq_o = st_q.irq;

endmodule

// File: rtl/rxfc_checker.sv
module rxfc_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic rx_valid_i,
    input logic rx_last_i,
    input logic rx_ovf_i,
    input logic out_valid_o,
    input logic stat_done_o,
    input logic stat_no_o,
    input logic stat_cr_o,
    input logic stat_lg_o,
    input logic stat_ov_o,
    input logic stat_trunc_o,
    input logic babble_irq_o
);

    // R10
    no_cr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(stat_no_o && stat_cr_o));

    // R9
    ov_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_ov_o |-> (!stat_no_o && !stat_cr_o));

    // R2
    flags_need_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_done_o |-> !(stat_no_o || stat_cr_o || stat_lg_o || stat_ov_o || stat_trunc_o));

    // R2
    done_after_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_done_o |-> $past(rx_valid_i && (rx_last_i || rx_ovf_i)));

    // R1
    fwd_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> $past(rx_valid_i && !rx_ovf_i));

    // R7
    irq_after_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        babble_irq_o |-> $past(rx_valid_i));

endmodule

bind rx_frame_classifier rxfc_checker i_rxfc_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_last_i    (rx_last_i),
    .rx_ovf_i     (rx_ovf_i),
    .out_valid_o  (out_valid_o),
    .stat_done_o  (stat_done_o),
    .stat_no_o    (stat_no_o),
    .stat_cr_o    (stat_cr_o),
    .stat_lg_o    (stat_lg_o),
    .stat_ov_o    (stat_ov_o),
    .stat_trunc_o (stat_trunc_o),
    .babble_irq_o (babble_irq_o)
);

// File: tb/test_rx_frame_classifier.sv
`timescale 1ns/1ps
module test_rx_frame_classifier;

    localparam int MAX_W = 11;
    localparam int TRUNC = 2047;
    localparam int BUF   = 2200;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic             rx_last;
    logic [2:0]       rx_dribble;
    logic             rx_ovf;
    logic [MAX_W-1:0] max_len;
    logic             out_valid;
    logic [7:0]       out_data;
    logic             done, f_no, f_cr, f_lg, f_ov, f_trunc, irq;

    always #2.5 clk = ~clk;

    rx_frame_classifier #(.MAX_W(MAX_W), .TRUNC_LEN(TRUNC)) i_rx_frame_classifier (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rx_valid_i   (rx_valid),
        .rx_data_i    (rx_data),
        .rx_last_i    (rx_last),
        .rx_dribble_i (rx_dribble),
        .rx_ovf_i     (rx_ovf),
        .max_len_i    (max_len),
        .out_valid_o  (out_valid),
        .out_data_o   (out_data),
        .stat_done_o  (done),
        .stat_no_o    (f_no),
        .stat_cr_o    (f_cr),
        .stat_lg_o    (f_lg),
        .stat_ov_o    (f_ov),
        .stat_trunc_o (f_trunc),
        .babble_irq_o (irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit finished = 0;

    logic [7:0] frm  [0:BUF-1];
    logic [7:0] obuf [0:BUF-1];
    int drive_cyc [0:BUF-1];
    int flen;
    int ocnt, done_cnt, irq_cnt, irq_cyc, done_cyc;
    logic [4:0] last_flags;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_valid) begin
            if (ocnt < BUF) obuf[ocnt] = out_data;
            ocnt++;
        end
        if (done) begin
            done_cnt++;
            done_cyc   = cyc;
            last_flags = {f_no, f_cr, f_lg, f_ov, f_trunc};
        end else if (f_no || f_cr || f_lg || f_ov || f_trunc) begin
            last_flags = 5'b11111;
        end
        if (irq) begin
            irq_cnt++;
            irq_cyc = cyc;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_add(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            if ((r[0] ^ d[b]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else                        r = r >> 1;
        end
        return r;
    endfunction

    // payload of n bytes followed by FCS, optional corruption afterwards
    task automatic build(input int n, input int seed, input bit corrupt);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            frm[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
            c = crc_add(c, frm[i]);
        end
        c = ~c;
        for (int k = 0; k < 4; k++) frm[n + k] = c[8*k +: 8];
        flen = n + 4;
        if (corrupt) frm[n / 2] = frm[n / 2] ^ 8'h10;
    endtask

    task automatic clear_mon();
        ocnt = 0; done_cnt = 0; irq_cnt = 0; irq_cyc = -1; done_cyc = -1;
        last_flags = 5'b0;
    endtask

    task automatic send(input int dribble, input int ovf_at,
                        input int max_first, input int max_after);
        clear_mon();
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            if (i == 0) max_len = MAX_W'(max_first);
            else        max_len = MAX_W'(max_after);
            rx_valid   = 1'b1;
            rx_data    = frm[i];
            rx_last    = (i == flen - 1);
            rx_dribble = (i == flen - 1) ? 3'(dribble) : 3'd0;
            rx_ovf     = (i == ovf_at);
            drive_cyc[i] = cyc;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_ovf = 1'b0; rx_dribble = 3'd0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int mism(input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (obuf[i] !== frm[i]) m++;
        return m;
    endfunction

    task automatic t_reset();
        clear_mon();
        repeat (3) @(negedge clk);
        chk("R2 reset done low", int'(done), 0);
        chk("R1 reset out_valid low", int'(out_valid) + ocnt, 0);
        chk("R7 reset irq low", int'(irq), 0);
    endtask

    task automatic t_good();
        build(40, 1, 0);
        send(0, -1, 1500, 1500);
        chk("R3 good frame flags", int'(last_flags), 0);
        chk("R2 one done", done_cnt, 1);
        chk("R2 done cycle", done_cyc, drive_cyc[flen - 1] + 1);
        chk("R1 forwarded count", ocnt, flen);
        chk("R1 forwarded bytes", mism(flen), 0);
    endtask

    task automatic t_badcrc();
        build(33, 2, 1);
        send(0, -1, 1500, 1500);
        chk("R4 cr only", int'(last_flags), 5'b01000);
    endtask

    task automatic t_dribble();
        build(25, 3, 1);
        send(5, -1, 1500, 1500);
        chk("R5 no only on bad crc", int'(last_flags), 5'b10000);
        build(25, 4, 0);
        send(7, -1, 1500, 1500);
        chk("R5 dribble with good crc clean", int'(last_flags), 0);
        build(10, 5, 1);
        send(1, -1, 1500, 1500);
        chk("R10 no without cr", int'(last_flags), 5'b10000);
    endtask

    task automatic t_len();
        build(26, 6, 0);
        send(0, -1, 30, 30);
        chk("R6 equal to max not long", int'(last_flags), 0);
        chk("R7 no irq at max", irq_cnt, 0);
        build(26, 7, 0);
        send(0, -1, 20, 20);
        chk("R6 long flag", int'(last_flags), 5'b00100);
        chk("R7 one irq", irq_cnt, 1);
        chk("R7 irq cycle", irq_cyc, drive_cyc[20] + 1);
        build(26, 8, 0);
        send(0, -1, 100, 5);
        chk("R6 max sampled at start", int'(last_flags), 0);
        chk("R7 no irq after late max change", irq_cnt, 0);
    endtask

    task automatic t_trunc();
        build(2049, 9, 0);
        send(0, -1, 2047, 2047);
        chk("R8 forwarded limited", ocnt, TRUNC);
        chk("R8 kept bytes intact", mism(TRUNC), 0);
        chk("R8 trunc and long flags", int'(last_flags), 5'b00101);
        chk("R7 irq at 2048th byte", irq_cyc, drive_cyc[2047] + 1);
    endtask

    task automatic t_ovf();
        build(16, 10, 0);
        send(0, 5, 1500, 1500);
        chk("R9 ov flag", int'(last_flags), 5'b00010);
        chk("R9 single done", done_cnt, 1);
        chk("R9 done cycle", done_cyc, drive_cyc[5] + 1);
        chk("R9 bytes before ovf only", ocnt, 5);
        build(16, 11, 1);
        send(0, 19, 1500, 1500);
        chk("R9 ov masks cr", int'(last_flags), 5'b00010);
        build(12, 12, 0);
        send(0, -1, 1500, 1500);
        chk("R9 next frame normal", int'(last_flags), 0);
        chk("R9 next frame bytes", ocnt, flen);
    endtask

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h0; rx_last = 1'b0;
        rx_dribble = 3'd0; rx_ovf = 1'b0; max_len = '0;
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_good();
        t_badcrc();
        t_dribble();
        t_len();
        t_trunc();
        t_ovf();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule